// File: doc/BRIEF.md
# Multi-layer pixel compositor

This block merges up to four video layers into a single 24-bit RGB pixel at each raster position. Each layer's pixel arrives already fetched and aligned to the current screen coordinate. Beside the pixel, each layer has a set of static controls: an enable, an inclusive on-screen rectangle, a depth select (RGB565 or 8-bit-per-channel in a 32-bit word), a component-order flag and an alpha source. The alpha source is either one constant for the whole layer or the top byte of each 32-bit pixel.

Stacking is fixed by index, and layer 0 is the topmost. Blending starts at the last layer, laid over black, and works up towards layer 0. The last layer can instead be replaced by an opaque constant background colour. The result is registered with a fixed two-cycle latency. The display valid and sync strobes are delayed by the same amount, so the blender drops into an existing raster pipeline.

Top module: `layer_compositor`

## Requirements
- R1: out_valid, out_hsync and out_vsync equal in_valid, in_hsync and in_vsync from two rising edges earlier. out_rgb carries the blend of the inputs sampled on that same edge.
- R2: Layer index sets priority, and layer 0 is topmost. A visible layer with effective alpha 255 fully hides every layer with a higher index.
- R3: A layer whose layer_on bit is 0 contributes nothing, whatever its pixel and other fields hold.
- R4: A layer is visible only where win_x0 <= pos_x <= win_x1 and win_y0 <= pos_y <= win_y1 (bounds inclusive). Outside that rectangle it is fully transparent.
- R5: With layer_wide = 0 the pixel is RGB565 in bits [15:0]: bits [15:11], [10:5] and [4:0] hold the first, middle and last component. Five-bit fields widen as {v, v[4:2]} and the six-bit field as {v, v[5:4]}.
- R6: With layer_wide = 1 the first, middle and last components are bits [23:16], [15:8] and [7:0] of the 32-bit word.
- R7: layer_bgr = 0 means the first component is red and the last is blue. layer_bgr = 1 swaps red and blue; green stays in the middle.
- R8: With constant alpha, a wide layer uses layer_k_alpha[7:0] as its alpha. A narrow layer uses layer_k_alpha[5:0] widened as {a, a[5:4]}, so 63 maps to 255.
- R9: With layer_pix_alpha = 1 on a wide layer, the alpha is pixel bits [31:24]. On a narrow layer the flag is ignored and the constant alpha applies.
- R10: Each channel becomes round((a*src + (255-a)*dst)/255). Blending runs from the last layer up to layer 0, and the starting colour is black (0).
- R11: With bg_mode = 1 the last layer's pixel and controls are ignored. The last layer is replaced by the opaque colour bg_color, with red in [23:16], green in [15:8] and blue in [7:0].
- R12: While rst_n is low, and on the first cycles after it rises, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Active-area strobe for the current position |
| in_hsync | input | 1 | Horizontal sync in |
| in_vsync | input | 1 | Vertical sync in |
| pos_x | input | COORD_W | Current column |
| pos_y | input | COORD_W | Current row |
| layer_pix | input | NUM_LAYERS*32 | Aligned pixel per layer, layer i in [32i+31:32i] |
| layer_on | input | NUM_LAYERS | Layer enable |
| layer_bgr | input | NUM_LAYERS | Blue-first component order |
| layer_wide | input | NUM_LAYERS | 1: 8-bit channels, 0: RGB565 |
| layer_pix_alpha | input | NUM_LAYERS | Take alpha from pixel bits [31:24] |
| layer_k_alpha | input | NUM_LAYERS*8 | Constant layer alpha |
| win_x0 | input | NUM_LAYERS*COORD_W | Left edge per layer |
| win_x1 | input | NUM_LAYERS*COORD_W | Right edge per layer |
| win_y0 | input | NUM_LAYERS*COORD_W | Top edge per layer |
| win_y1 | input | NUM_LAYERS*COORD_W | Bottom edge per layer |
| bg_mode | input | 1 | Replace the last layer with bg_color |
| bg_color | input | 24 | Background colour |
| out_valid | output | 1 | Delayed active strobe |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_rgb | output | 24 | Blended pixel, red in [23:16] |

## Verification
The assertions assume that the layer controls and window bounds are sampled together with the pixel that uses them. They also assume that every layer rectangle is well formed (win_x0 <= win_x1 and win_y0 <= win_y1).

The stimulus changes controls only in the same cycle as the pixel that the expected value is computed from. Random rectangles are built by ordering two random coordinates, so they never invert. The latency check arms itself only after two edges out of reset, so it never compares against values from before reset.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  typedef struct packed {
    rgb_t       c;
    logic [7:0] a;
  } wpix_t;

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  // rounded x/255 for x <= 255*255
  function automatic logic [7:0] div255(input logic [15:0] x);
    logic [16:0] t;
    logic [16:0] s;
    t = {1'b0, x} + 17'd128;
    s = t + (t >> 8);
    return s[15:8];
  endfunction

  function automatic logic [7:0] mix_ch(input logic [7:0] s, input logic [7:0] d,
                                        input logic [7:0] a);
    logic [15:0] x;
    x = 16'(a) * 16'(s) + 16'(8'd255 - a) * 16'(d);
    return div255(x);
  endfunction

  function automatic rgb_t mix_rgb(input wpix_t src, input rgb_t dst);
    rgb_t o;
    o.r = mix_ch(src.c.r, dst.r, src.a);
    o.g = mix_ch(src.c.g, dst.g, src.a);
    o.b = mix_ch(src.c.b, dst.b, src.a);
    return o;
  endfunction
endpackage

// File: rtl/lc_layer_front.sv
module lc_layer_front import lc_pkg::*; #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        pix,
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic               on,
  input  logic               bgr,
  input  logic               wide,
  input  logic               pix_alpha,
  input  logic [7:0]         k_alpha,
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] y1,
  output wpix_t              q
);
  logic [7:0] first_c, mid_c, last_c;
  logic [7:0] a_nom, a_eff;
  logic       in_rect, visible;
  rgb_t       col;

  always_comb begin
    if (wide) begin
      first_c = pix[23:16];
      mid_c   = pix[15:8];
      last_c  = pix[7:0];
      a_nom   = pix_alpha ? pix[31:24] : k_alpha;
    end else begin
      first_c = widen5(pix[15:11]);
      mid_c   = widen6(pix[10:5]);
      last_c  = widen5(pix[4:0]);
      a_nom   = widen6(k_alpha[5:0]);
    end
    col.r   = bgr ? last_c : first_c;
    col.g   = mid_c;
    col.b   = bgr ? first_c : last_c;
    in_rect = (pos_x >= x0) && (pos_x <= x1) && (pos_y >= y0) && (pos_y <= y1);
    visible = on && in_rect;
    a_eff   = visible ? a_nom : 8'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= '{c: col, a: a_eff};
  end

  assert_off_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!on) |=> (q.a == 8'd0));

  assert_outside_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos_x > x1) || (pos_x < x0) || (pos_y > y1) || (pos_y < y0)) |=> (q.a == 8'd0));

  assert_pixel_alpha_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (on && wide && pix_alpha && (pos_x >= x0) && (pos_x <= x1) && (pos_y >= y0) && (pos_y <= y1))
      |=> (q.a == $past(pix[31:24])));
endmodule

// File: rtl/lc_blend_chain.sv
module lc_blend_chain import lc_pkg::*; #(
  parameter int NUM_LAYERS = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  wpix_t lay [NUM_LAYERS],
  input  logic  bg_on,
  input  rgb_t  bg,
  output rgb_t  mixed
);
  rgb_t acc [NUM_LAYERS+1];
  logic upper_clear, all_clear;

  assign acc[NUM_LAYERS] = '0;

  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_stage
    if (i == NUM_LAYERS - 1) begin : g_last
      assign acc[i] = bg_on ? bg : mix_rgb(lay[i], acc[i+1]);
    end else begin : g_mid
      assign acc[i] = mix_rgb(lay[i], acc[i+1]);
    end
  end

  always_comb begin
    upper_clear = 1'b1;
    for (int j = 0; j < NUM_LAYERS - 1; j++)
      if (lay[j].a != 8'd0) upper_clear = 1'b0;
    all_clear = upper_clear && (lay[NUM_LAYERS-1].a == 8'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mixed <= '0;
    else        mixed <= acc[0];
  end

  assert_top_opaque_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lay[0].a == 8'd255) |=> (mixed == $past(lay[0].c)));

  assert_bg_shows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_on && upper_clear) |=> (mixed == $past(bg)));

  assert_black_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bg_on && all_clear) |=> (mixed == '0));
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor import lc_pkg::*; #(
  parameter int NUM_LAYERS = 4,
  parameter int COORD_W    = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_hsync,
  input  logic                          in_vsync,
  input  logic [COORD_W-1:0]            pos_x,
  input  logic [COORD_W-1:0]            pos_y,
  input  logic [NUM_LAYERS*32-1:0]      layer_pix,
  input  logic [NUM_LAYERS-1:0]         layer_on,
  input  logic [NUM_LAYERS-1:0]         layer_bgr,
  input  logic [NUM_LAYERS-1:0]         layer_wide,
  input  logic [NUM_LAYERS-1:0]         layer_pix_alpha,
  input  logic [NUM_LAYERS*8-1:0]       layer_k_alpha,
  input  logic [NUM_LAYERS*COORD_W-1:0] win_x0,
  input  logic [NUM_LAYERS*COORD_W-1:0] win_x1,
  input  logic [NUM_LAYERS*COORD_W-1:0] win_y0,
  input  logic [NUM_LAYERS*COORD_W-1:0] win_y1,
  input  logic                          bg_mode,
  input  logic [23:0]                   bg_color,
  output logic                          out_valid,
  output logic                          out_hsync,
  output logic                          out_vsync,
  output logic [23:0]                   out_rgb
);
  localparam int LAT = 2;

  wpix_t      stage [NUM_LAYERS];
  rgb_t       bg_q, mixed;
  logic       bg_mode_q;
  logic [LAT-1:0] vd, hd, sd;
  logic [1:0] warm;

  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_layer
    lc_layer_front #(.COORD_W(COORD_W)) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix       (layer_pix[i*32 +: 32]),
      .pos_x     (pos_x),
      .pos_y     (pos_y),
      .on        (layer_on[i]),
      .bgr       (layer_bgr[i]),
      .wide      (layer_wide[i]),
      .pix_alpha (layer_pix_alpha[i]),
      .k_alpha   (layer_k_alpha[i*8 +: 8]),
      .x0        (win_x0[i*COORD_W +: COORD_W]),
      .x1        (win_x1[i*COORD_W +: COORD_W]),
      .y0        (win_y0[i*COORD_W +: COORD_W]),
      .y1        (win_y1[i*COORD_W +: COORD_W]),
      .q         (stage[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bg_q      <= '0;
      bg_mode_q <= 1'b0;
      vd        <= '0;
      hd        <= '0;
      sd        <= '0;
      warm      <= '0;
    end else begin
      bg_q      <= bg_color;
      bg_mode_q <= bg_mode;
      vd        <= {vd[LAT-2:0], in_valid};
      hd        <= {hd[LAT-2:0], in_hsync};
      sd        <= {sd[LAT-2:0], in_vsync};
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  lc_blend_chain #(.NUM_LAYERS(NUM_LAYERS)) u_blend (
    .clk   (clk),
    .rst_n (rst_n),
    .lay   (stage),
    .bg_on (bg_mode_q),
    .bg    (bg_q),
    .mixed (mixed)
  );

  assign out_valid = vd[LAT-1];
  assign out_hsync = hd[LAT-1];
  assign out_vsync = sd[LAT-1];
  assign out_rgb   = mixed;

  assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> ((out_hsync == $past(in_hsync, 2)) && (out_vsync == $past(in_vsync, 2))));

  assert_quiet_after_reset_R12: assert property (@(posedge clk)
    (!rst_n) |=> (!out_valid && (out_rgb == 24'd0)));
endmodule

// File: tb/layer_compositor_test.sv
module layer_compositor_test;
  localparam int NL = 4;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_hsync = 0, in_vsync = 0;
  logic [CW-1:0] pos_x = '0, pos_y = '0;
  logic [NL*32-1:0] layer_pix = '0;
  logic [NL-1:0] layer_on = '0, layer_bgr = '0, layer_wide = '0, layer_pix_alpha = '0;
  logic [NL*8-1:0] layer_k_alpha = '0;
  logic [NL*CW-1:0] win_x0 = '0, win_x1 = '0, win_y0 = '0, win_y1 = '0;
  logic bg_mode = 0;
  logic [23:0] bg_color = '0;
  logic out_valid, out_hsync, out_vsync;
  logic [23:0] out_rgb;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic v, hs, vs;
    logic [23:0] rgb;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  layer_compositor #(.NUM_LAYERS(NL), .COORD_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync),
    .pos_x(pos_x), .pos_y(pos_y), .layer_pix(layer_pix), .layer_on(layer_on),
    .layer_bgr(layer_bgr), .layer_wide(layer_wide), .layer_pix_alpha(layer_pix_alpha),
    .layer_k_alpha(layer_k_alpha), .win_x0(win_x0), .win_x1(win_x1), .win_y0(win_y0),
    .win_y1(win_y1), .bg_mode(bg_mode), .bg_color(bg_color), .out_valid(out_valid),
    .out_hsync(out_hsync), .out_vsync(out_vsync), .out_rgb(out_rgb));

  // independent model of the requirements
  function automatic logic [23:0] model(int x, int y);
    int r, g, b, sr, sg, sb, a, f, m, l, last;
    logic [31:0] p;
    r = 0; g = 0; b = 0;
    last = NL;
    if (bg_mode) begin
      r = bg_color[23:16]; g = bg_color[15:8]; b = bg_color[7:0];
      last = NL - 1;
    end
    for (int i = last - 1; i >= 0; i--) begin
      p = layer_pix[i*32 +: 32];
      if (!layer_on[i]) continue;
      if (x < int'(win_x0[i*CW +: CW]) || x > int'(win_x1[i*CW +: CW]) ||
          y < int'(win_y0[i*CW +: CW]) || y > int'(win_y1[i*CW +: CW])) continue;
      if (layer_wide[i]) begin
        f = p[23:16]; m = p[15:8]; l = p[7:0];
        a = layer_pix_alpha[i] ? int'(p[31:24]) : int'(layer_k_alpha[i*8 +: 8]);
      end else begin
        f = int'(p[15:11]) * 8 + int'(p[15:11]) / 4;
        m = int'(p[10:5]) * 4 + int'(p[10:5]) / 16;
        l = int'(p[4:0]) * 8 + int'(p[4:0]) / 4;
        a = int'(layer_k_alpha[i*8 +: 6]) * 4 + int'(layer_k_alpha[i*8 +: 6]) / 16;
      end
      sg = m;
      if (layer_bgr[i]) begin sr = l; sb = f; end
      else begin sr = f; sb = l; end
      r = (2 * (a * sr + (255 - a) * r) + 255) / 510;
      g = (2 * (a * sg + (255 - a) * g) + 255) / 510;
      b = (2 * (a * sb + (255 - a) * b) + 255) / 510;
    end
    return {8'(r), 8'(g), 8'(b)};
  endfunction

  task automatic set_layer(int i, bit on, bit wide, bit bgr, bit pa, logic [7:0] ka,
                           logic [31:0] pix);
    layer_on[i] = on; layer_wide[i] = wide; layer_bgr[i] = bgr; layer_pix_alpha[i] = pa;
    layer_k_alpha[i*8 +: 8] = ka;
    layer_pix[i*32 +: 32] = pix;
  endtask

  task automatic set_win(int i, int x0, int x1, int y0, int y1);
    win_x0[i*CW +: CW] = CW'(x0); win_x1[i*CW +: CW] = CW'(x1);
    win_y0[i*CW +: CW] = CW'(y0); win_y1[i*CW +: CW] = CW'(y1);
  endtask

  // driver: controls are already set; apply position and strobes, push expectation
  task automatic drive(int x, int y, bit v, bit hs, bit vs, string tag);
    exp_t e;
    pos_x = CW'(x); pos_y = CW'(y);
    in_valid = v; in_hsync = hs; in_vsync = vs;
    e.v = v; e.hs = hs; e.vs = vs; e.rgb = model(x, y); e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic expect_rgb(logic [23:0] want, string tag);
    checks++;
    if (q[q.size()-1].rgb !== want) begin
      fails++;
      $display("FAIL %s model sanity: got %06h expected %06h", tag, q[q.size()-1].rgb, want);
    end
  endtask

  // monitor: result of a drive appears two edges later
  always @(posedge clk) begin
    #2;
    if (!done && q.size() >= 2) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (out_valid !== e.v || out_hsync !== e.hs || out_vsync !== e.vs || out_rgb !== e.rgb) begin
        fails++;
        $display("FAIL %s: got v%0b h%0b s%0b rgb=%06h expected v%0b h%0b s%0b rgb=%06h",
                 e.tag, out_valid, out_hsync, out_vsync, out_rgb, e.v, e.hs, e.vs, e.rgb);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) set_win(i, 0, 4095, 0, 4095);
    // R12: stimulus during reset must not reach the outputs
    set_layer(0, 1, 1, 0, 0, 8'hFF, 32'h00FFFFFF);
    in_valid = 1; in_hsync = 1; in_vsync = 1;
    repeat (5) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_hsync !== 0 || out_vsync !== 0 || out_rgb !== 24'd0) begin
      fails++;
      $display("FAIL R12: got v%0b rgb=%06h expected v0 rgb=000000", out_valid, out_rgb);
    end
    rst_n = 1;
    set_layer(0, 0, 0, 0, 0, 8'h00, 32'h0);
    in_valid = 0; in_hsync = 0; in_vsync = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_rgb !== 24'd0) begin
      fails++;
      $display("FAIL R12: got v%0b rgb=%06h expected v0 rgb=000000", out_valid, out_rgb);
    end

    // R6: wide layer, opaque
    set_layer(1, 1, 1, 0, 0, 8'hFF, 32'h00A1B2C3);
    drive(3, 3, 1, 0, 0, "R6");
    expect_rgb(24'hA1B2C3, "R6");
    // R2: layer 0 opaque hides layer 1
    set_layer(0, 1, 1, 0, 0, 8'hFF, 32'h00112233);
    drive(3, 3, 1, 0, 0, "R2");
    expect_rgb(24'h112233, "R2");
    // R2: layer 1 opaque hides layer 2
    set_layer(0, 0, 1, 0, 0, 8'hFF, 32'h00112233);
    set_layer(2, 1, 1, 0, 0, 8'hFF, 32'h00777777);
    drive(3, 3, 1, 0, 0, "R2");
    // R3: layer 0 disabled, its fields are irrelevant
    set_layer(0, 0, 1, 1, 1, 8'hFF, 32'hFF445566);
    drive(3, 3, 1, 0, 0, "R3");
    expect_rgb(24'hA1B2C3, "R3");
    // R4: rectangle edges inclusive
    set_layer(0, 1, 1, 0, 0, 8'hFF, 32'h00445566);
    set_win(0, 10, 20, 5, 7);
    drive(20, 7, 1, 0, 0, "R4");
    drive(10, 5, 1, 0, 0, "R4");
    drive(21, 7, 1, 0, 0, "R4");
    expect_rgb(24'hA1B2C3, "R4");
    drive(9, 6, 1, 0, 0, "R4");
    drive(15, 8, 1, 0, 0, "R4");
    drive(15, 4, 1, 0, 0, "R4");
    set_win(0, 0, 4095, 0, 4095);
    // R5: RGB565 widening, constant alpha 63 is opaque
    set_layer(0, 1, 0, 0, 0, 8'h3F, 32'h0000F81F);
    drive(1, 1, 1, 0, 0, "R5");
    expect_rgb(24'hFF00FF, "R5");
    set_layer(0, 1, 0, 0, 0, 8'h3F, 32'h00001234);
    drive(1, 1, 1, 0, 0, "R5");
    expect_rgb(24'h1045A5, "R5");
    // R7: blue-first order, wide and narrow
    set_layer(0, 1, 1, 1, 0, 8'hFF, 32'h00A1B2C3);
    drive(1, 1, 1, 0, 0, "R7");
    expect_rgb(24'hC3B2A1, "R7");
    set_layer(0, 1, 0, 1, 0, 8'h3F, 32'h00001234);
    drive(1, 1, 1, 0, 0, "R7");
    expect_rgb(24'hA54510, "R7");
    // R8: constant alpha, narrow and wide
    set_layer(0, 1, 0, 0, 0, 8'hE0, 32'h0000FFFF);
    drive(1, 1, 1, 0, 0, "R8");
    set_layer(0, 1, 1, 0, 0, 8'h80, 32'h00FF0000);
    drive(1, 1, 1, 0, 0, "R8");
    // R9: per-pixel alpha on wide, ignored on narrow
    set_layer(0, 1, 1, 0, 1, 8'h00, 32'h40FF00FF);
    drive(1, 1, 1, 0, 0, "R9");
    set_layer(0, 1, 0, 0, 1, 8'h3F, 32'h00000000);
    drive(1, 1, 1, 0, 0, "R9");
    expect_rgb(24'h000000, "R9");
    // R10: four partial layers over black
    set_layer(0, 1, 1, 0, 0, 8'h55, 32'h00FF8000);
    set_layer(1, 1, 1, 0, 1, 8'h00, 32'hA000FF80);
    set_layer(2, 1, 0, 0, 0, 8'h20, 32'h0000ABCD);
    set_layer(3, 1, 1, 1, 0, 8'hC0, 32'h00123456);
    drive(2, 2, 1, 0, 0, "R10");
    set_layer(0, 0, 1, 0, 0, 8'h00, 32'h0); set_layer(1, 0, 1, 0, 0, 8'h00, 32'h0);
    set_layer(2, 0, 1, 0, 0, 8'h00, 32'h0); set_layer(3, 0, 1, 0, 0, 8'h00, 32'h0);
    drive(2, 2, 1, 0, 0, "R10");
    expect_rgb(24'h000000, "R10");
    // R11: background replaces last layer
    bg_mode = 1; bg_color = 24'h3366CC;
    set_layer(3, 1, 1, 0, 0, 8'hFF, 32'h00FFFFFF);
    drive(2, 2, 1, 0, 0, "R11");
    expect_rgb(24'h3366CC, "R11");
    set_layer(0, 1, 1, 0, 0, 8'h80, 32'h00FFFFFF);
    drive(2, 2, 1, 0, 0, "R11");
    bg_mode = 0;
    drive(2, 2, 1, 0, 0, "R11");
    // R1: strobes ride along with the data
    drive(0, 0, 0, 1, 0, "R1");
    drive(0, 0, 0, 1, 1, "R1");
    drive(0, 0, 1, 0, 1, "R1");
    drive(0, 0, 0, 0, 0, "R1");
    drive(0, 0, 1, 1, 1, "R1");
    // R10: random sweep over all fields
    for (int n = 0; n < 400; n++) begin
      bg_mode = 1'($urandom);
      bg_color = 24'($urandom);
      for (int i = 0; i < NL; i++) begin
        int ax, bx, ay, by;
        ax = $urandom % 64; bx = $urandom % 64; ay = $urandom % 64; by = $urandom % 64;
        set_layer(i, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  8'($urandom), 32'($urandom));
        set_win(i, (ax < bx) ? ax : bx, (ax < bx) ? bx : ax,
                   (ay < by) ? ay : by, (ay < by) ? by : ay);
      end
      drive($urandom % 64, $urandom % 64, 1'($urandom), 1'($urandom), 1'($urandom), "R10");
    end
    repeat (3) drive(0, 0, 0, 0, 0, "R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule